// File: doc/BRIEF.md
# Packed Negated Multiply-Add Operand Router

This block sits between instruction decode and a bank of single-precision fused multiply-add lanes. It serves the packed negated multiply-add operation, which computes `-(a*b) + c` in every 32-bit lane. It takes one request: an opcode byte, a length bit, and three operand vectors. The first vector is both the destination and the first source. The block works out which of three operand orderings the opcode asks for. It then hands each lane a multiplicand, a multiplier and an addend, and marks the lanes that take part.

When the lanes return their 32-bit results and exception flags, the block builds the destination vector in the next cycle. In the short form only four lanes carry results and the upper half of the destination is cleared. The per-lane flags of the active lanes are ORed into one flag word. An opcode byte outside the three known forms is rejected without touching the lanes, and the destination is returned unchanged.

The control is a five-state machine:

- **IDLE** accepts a request.
- **ISSUE** drives the lanes for one cycle.
- **WAIT** holds until the lane results return.
- **DONE** presents the result for one cycle.
- **REJECT** presents the unchanged destination with the illegal flag for one cycle.

The transitions are:

- IDLE→ISSUE: a legal request is accepted.
- IDLE→REJECT: an illegal request is accepted.
- ISSUE→WAIT: always, after one cycle.
- WAIT→DONE: lane results return.
- DONE→IDLE and REJECT→IDLE: always, after one cycle.

Top module: `fnm_router`

## Requirements
- R1: Opcode byte 0x9C routes each lane as multiplicand = in_dst, multiplier = in_src3, addend = in_src2.
- R2: Opcode byte 0xAC routes each lane as multiplicand = in_src2, multiplier = in_dst, addend = in_src3.
- R3: Opcode byte 0xBC routes each lane as multiplicand = in_src2, multiplier = in_src3, addend = in_dst.
- R4: Lane i uses bits 32*i+31..32*i of every vector. With in_wide=1 lane_active is 8'hFF. With in_wide=0 it is 8'h0F, and the operand outputs of lanes 4..7 are zero.
- R5: With in_wide=0, out_dest[255:128] is zero whatever res_data carries there.
- R6: The active lanes of out_dest equal the matching lanes of res_data captured with res_valid.
- R7: Any other opcode byte gives out_valid=1 and out_illegal=1 in the cycle after acceptance, with out_dest = in_dst and out_flags = 0. lane_valid stays low.
- R8: res_flags holds 5 bits per lane at bits 5*i+4..5*i. out_flags is the OR of the flag fields of the active lanes only.
- R9: lane_valid is high for exactly the one cycle after a legal request is accepted. out_valid is high for exactly the one cycle after res_valid is sampled in WAIT, with out_illegal=0.
- R10: in_ready is high only in IDLE. in_valid while in_ready is low is ignored, and res_valid outside WAIT is ignored.
- R11: After reset, in_ready=1, lane_valid=0, out_valid=0, out_illegal=0, and out_dest and out_flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request taken |
| in_opcode | input | 8 | Opcode byte selecting the operand form |
| in_wide | input | 1 | 1: eight lanes, 0: four lanes |
| in_dst | input | 256 | Destination and first source |
| in_src2 | input | 256 | Second source |
| in_src3 | input | 256 | Third source |
| lane_valid | output | 1 | Lane operands valid |
| lane_active | output | 8 | Lanes taking part |
| lane_mcand | output | 256 | Per-lane multiplicand |
| lane_mplier | output | 256 | Per-lane multiplier |
| lane_addend | output | 256 | Per-lane addend |
| res_valid | input | 1 | Lane results returned |
| res_data | input | 256 | Per-lane 32-bit results |
| res_flags | input | 40 | Per-lane 5-bit exception flags |
| out_valid | output | 1 | Destination value valid |
| out_illegal | output | 1 | Opcode was not a known form |
| out_dest | output | 256 | Assembled destination |
| out_flags | output | 5 | ORed flags of active lanes |

## Verification
The bench builds the block with its default parameters: eight lanes of 32 bits and five flag bits per lane. With these values both the four-lane and the eight-lane lengths can be reached, so upper-half clearing and flag masking can both be observed. Random opcodes are mixed with the three legal bytes, and the lane return delay is varied. This exercises the rejection path, the WAIT hold, and ignored requests that arrive while the block is busy.

// File: rtl/fnm_pkg.sv
package fnm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_REJECT
    } fnm_state_t;

    typedef enum logic [1:0] {
        FORM_NONE,
        FORM_132,
        FORM_213,
        FORM_231
    } fnm_form_t;

    localparam logic [7:0] OPC_132 = 8'h9C;
    localparam logic [7:0] OPC_213 = 8'hAC;
    localparam logic [7:0] OPC_231 = 8'hBC;
endpackage

// File: rtl/fnm_decode.sv
module fnm_decode
    import fnm_pkg::*;
(
    input  logic [7:0] opcode,
    output fnm_form_t  form,
    output logic       legal
);
    always_comb begin
        unique case (opcode)
            OPC_132: form = FORM_132;
            OPC_213: form = FORM_213;
            OPC_231: form = FORM_231;
            default: form = FORM_NONE;
        endcase
        legal = (form != FORM_NONE);
    end
endmodule

// File: rtl/fnm_route.sv
module fnm_route
    import fnm_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 32
) (
    input  fnm_form_t                form,
    input  logic                     wide,
    input  logic [LANES*LANE_W-1:0]  dst,
    input  logic [LANES*LANE_W-1:0]  src2,
    input  logic [LANES*LANE_W-1:0]  src3,
    output logic [LANES*LANE_W-1:0]  mcand,
    output logic [LANES*LANE_W-1:0]  mplier,
    output logic [LANES*LANE_W-1:0]  addend,
    output logic [LANES-1:0]         active
);
    localparam int NARROW = LANES / 2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] d, b, c;
        logic              on;
        assign d  = dst [g*LANE_W +: LANE_W];
        assign b  = src2[g*LANE_W +: LANE_W];
        assign c  = src3[g*LANE_W +: LANE_W];
        assign on = wide || (g < NARROW);
        assign active[g] = on;
        always_comb begin
            mcand [g*LANE_W +: LANE_W] = '0;
            mplier[g*LANE_W +: LANE_W] = '0;
            addend[g*LANE_W +: LANE_W] = '0;
            if (on) begin
                unique case (form)
                    FORM_132: begin
                        mcand [g*LANE_W +: LANE_W] = d;
                        mplier[g*LANE_W +: LANE_W] = c;
                        addend[g*LANE_W +: LANE_W] = b;
                    end
                    FORM_213: begin
                        mcand [g*LANE_W +: LANE_W] = b;
                        mplier[g*LANE_W +: LANE_W] = d;
                        addend[g*LANE_W +: LANE_W] = c;
                    end
                    FORM_231: begin
                        mcand [g*LANE_W +: LANE_W] = b;
                        mplier[g*LANE_W +: LANE_W] = c;
                        addend[g*LANE_W +: LANE_W] = d;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fnm_pack.sv
module fnm_pack #(
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    parameter int FLAG_W = 5
) (
    input  logic                     wide,
    input  logic [LANES*LANE_W-1:0]  res_data,
    input  logic [LANES*FLAG_W-1:0]  res_flags,
    output logic [LANES*LANE_W-1:0]  dest,
    output logic [FLAG_W-1:0]        flags
);
    localparam int NARROW = LANES / 2;

    logic [LANES-1:0] keep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign keep[g] = wide || (g < NARROW);
        assign dest[g*LANE_W +: LANE_W] = keep[g] ? res_data[g*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        flags = '0;
        for (int i = 0; i < LANES; i++) begin
            if (keep[i]) flags = flags | res_flags[i*FLAG_W +: FLAG_W];
        end
    end
endmodule

// File: rtl/fnm_router.sv
module fnm_router
    import fnm_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    parameter int FLAG_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [7:0]               in_opcode,
    input  logic                     in_wide,
    input  logic [LANES*LANE_W-1:0]  in_dst,
    input  logic [LANES*LANE_W-1:0]  in_src2,
    input  logic [LANES*LANE_W-1:0]  in_src3,
    output logic                     lane_valid,
    output logic [LANES-1:0]         lane_active,
    output logic [LANES*LANE_W-1:0]  lane_mcand,
    output logic [LANES*LANE_W-1:0]  lane_mplier,
    output logic [LANES*LANE_W-1:0]  lane_addend,
    input  logic                     res_valid,
    input  logic [LANES*LANE_W-1:0]  res_data,
    input  logic [LANES*FLAG_W-1:0]  res_flags,
    output logic                     out_valid,
    output logic                     out_illegal,
    output logic [LANES*LANE_W-1:0]  out_dest,
    output logic [FLAG_W-1:0]        out_flags
);
    localparam int VEC_W = LANES * LANE_W;
    localparam int HALF  = VEC_W / 2;

    fnm_state_t state_q, state_d;
    fnm_form_t  form;
    logic       legal, wide_q, take;

    logic [VEC_W-1:0]  mcand_c, mplier_c, addend_c, dest_c;
    logic [LANES-1:0]  active_c;
    logic [FLAG_W-1:0] flags_c;

    fnm_decode u_dec (.opcode(in_opcode), .form(form), .legal(legal));

    fnm_route #(.LANES(LANES), .LANE_W(LANE_W)) u_route (
        .form(form), .wide(in_wide), .dst(in_dst), .src2(in_src2), .src3(in_src3),
        .mcand(mcand_c), .mplier(mplier_c), .addend(addend_c), .active(active_c)
    );

    fnm_pack #(.LANES(LANES), .LANE_W(LANE_W), .FLAG_W(FLAG_W)) u_pack (
        .wide(wide_q), .res_data(res_data), .res_flags(res_flags),
        .dest(dest_c), .flags(flags_c)
    );

    assign take = in_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = legal ? ST_ISSUE : ST_REJECT;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (res_valid) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_mcand  <= '0;
            lane_mplier <= '0;
            lane_addend <= '0;
            lane_active <= '0;
            wide_q      <= 1'b0;
            out_dest    <= '0;
            out_flags   <= '0;
        end else begin
            if (take && legal) begin
                lane_mcand  <= mcand_c;
                lane_mplier <= mplier_c;
                lane_addend <= addend_c;
                lane_active <= active_c;
                wide_q      <= in_wide;
            end
            if (take && !legal) begin
                out_dest  <= in_dst;
                out_flags <= '0;
            end
            if (state_q == ST_WAIT && res_valid) begin
                out_dest  <= dest_c;
                out_flags <= flags_c;
            end
        end
    end

    // outputs from state
    always_comb begin
        in_ready    = (state_q == ST_IDLE);
        lane_valid  = (state_q == ST_ISSUE);
        out_valid   = (state_q == ST_DONE) || (state_q == ST_REJECT);
        out_illegal = (state_q == ST_REJECT);
    end

    AST_LANE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid |=> !lane_valid);                                          // R9
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !lane_valid && !out_valid && res_valid) |=> (out_valid && !out_illegal)); // R9
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);                                // R10
    AST_REJECT_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !legal) |=> (out_illegal && !lane_valid));   // R7
    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_flags == '0));                                   // R7
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal && !wide_q) |-> (out_dest[VEC_W-1:HALF] == '0)); // R5
    AST_NARROW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && !lane_active[LANES-1]) |-> (lane_mcand[VEC_W-1:HALF] == '0)); // R4
endmodule

// File: tb/test_fnm_router.sv
module test_fnm_router;
    localparam int LANES = 8;
    localparam int LW = 32;
    localparam int FW = 5;
    localparam int VW = LANES * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_wide = 1'b0, res_valid = 1'b0;
    logic [7:0] in_opcode = '0;
    logic [VW-1:0] in_dst = '0, in_src2 = '0, in_src3 = '0, res_data = '0;
    logic [LANES*FW-1:0] res_flags = '0;
    logic in_ready, lane_valid, out_valid, out_illegal;
    logic [LANES-1:0] lane_active;
    logic [VW-1:0] lane_mcand, lane_mplier, lane_addend, out_dest;
    logic [FW-1:0] out_flags;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fnm_router #(.LANES(LANES), .LANE_W(LW), .FLAG_W(FW)) i_fnm_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_wide(in_wide), .in_dst(in_dst), .in_src2(in_src2),
        .in_src3(in_src3), .lane_valid(lane_valid), .lane_active(lane_active),
        .lane_mcand(lane_mcand), .lane_mplier(lane_mplier), .lane_addend(lane_addend),
        .res_valid(res_valid), .res_data(res_data), .res_flags(res_flags),
        .out_valid(out_valid), .out_illegal(out_illegal), .out_dest(out_dest),
        .out_flags(out_flags)
    );

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] rvec();
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*LW +: LW] = $urandom;
        return v;
    endfunction

    function automatic logic [VW-1:0] lmask(input logic wide);
        return wide ? {VW{1'b1}} : {{(VW/2){1'b0}}, {(VW/2){1'b1}}};
    endfunction

    // which: 0 multiplicand, 1 multiplier, 2 addend
    function automatic logic [VW-1:0] exp_op(input logic [7:0] opc, input int which, input logic wide,
                                             input logic [VW-1:0] d, input logic [VW-1:0] b,
                                             input logic [VW-1:0] c);
        logic [VW-1:0] r;
        case (opc)
            8'h9C: r = (which == 0) ? d : (which == 1) ? c : b;
            8'hAC: r = (which == 0) ? b : (which == 1) ? d : c;
            default: r = (which == 0) ? b : (which == 1) ? c : d;
        endcase
        return r & lmask(wide);
    endfunction

    function automatic logic [FW-1:0] exp_flags(input logic wide, input logic [LANES*FW-1:0] f);
        logic [FW-1:0] o = '0;
        for (int i = 0; i < (wide ? LANES : LANES / 2); i++) o |= f[i*FW +: FW];
        return o;
    endfunction

    task automatic run_op(input logic [7:0] opc, input logic wide, input int delay, input logic junk);
        logic [VW-1:0] d, b, c, rd;
        logic [LANES*FW-1:0] rf;
        logic legal;
        string rq;
        legal = (opc == 8'h9C) || (opc == 8'hAC) || (opc == 8'hBC);
        rq = (opc == 8'h9C) ? "R1" : (opc == 8'hAC) ? "R2" : "R3";
        d = rvec(); b = rvec(); c = rvec(); rd = rvec();
        rf = {$urandom, $urandom};
        @(negedge clk);
        in_valid = 1'b1; in_opcode = opc; in_wide = wide;
        in_dst = d; in_src2 = b; in_src3 = c;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 in_ready busy", {255'd0, in_ready}, '0);
        if (!legal) begin
            chk("R7 reject out_valid", {255'd0, out_valid}, 256'd1);
            chk("R7 reject illegal", {255'd0, out_illegal}, 256'd1);
            chk("R7 reject dest", out_dest, d);
            chk("R7 reject flags", {251'd0, out_flags}, '0);
            chk("R7 no lane_valid", {255'd0, lane_valid}, '0);
            @(posedge clk);
            @(negedge clk);
            chk("R7 back to idle", {254'd0, out_valid, in_ready}, 256'd1);
            return;
        end
        chk("R9 lane_valid", {255'd0, lane_valid}, 256'd1);
        chk({rq, " mcand"}, lane_mcand, exp_op(opc, 0, wide, d, b, c));
        chk({rq, " mplier"}, lane_mplier, exp_op(opc, 1, wide, d, b, c));
        chk({rq, " addend"}, lane_addend, exp_op(opc, 2, wide, d, b, c));
        chk("R4 lane_active", {248'd0, lane_active}, wide ? 256'hFF : 256'h0F);
        // stray result before WAIT is ignored (R10); junk requests while busy are ignored
        res_valid = 1'b1;
        if (junk) begin in_valid = 1'b1; in_opcode = 8'h9C; end
        for (int k = 0; k <= delay; k++) begin
            @(posedge clk);
            @(negedge clk);
            res_valid = 1'b0;
            chk("R9 lane_valid single", {255'd0, lane_valid}, '0);
            chk("R10 no early out_valid", {255'd0, out_valid}, '0);
        end
        in_valid = 1'b0;
        res_valid = 1'b1; res_data = rd; res_flags = rf;
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b0;
        chk("R9 out_valid", {254'd0, out_valid, out_illegal}, 256'd2);
        chk(wide ? "R6 dest" : "R5 dest", out_dest, rd & lmask(wide));
        chk("R8 flags", {251'd0, out_flags}, {251'd0, exp_flags(wide, rf)});
        @(posedge clk);
        @(negedge clk);
        chk("R9 out_valid single", {254'd0, out_valid, in_ready}, 256'd1);
    endtask

    initial begin
        #(5 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset ready/valid", {252'd0, in_ready, lane_valid, out_valid, out_illegal}, 256'h8);
        chk("R11 reset dest", out_dest, '0);
        chk("R11 reset flags", {251'd0, out_flags}, '0);
        rst_n = 1'b1;
        // directed corners
        run_op(8'h9C, 1'b1, 0, 1'b0);
        run_op(8'hAC, 1'b1, 2, 1'b1);
        run_op(8'hBC, 1'b1, 1, 1'b0);
        run_op(8'h9C, 1'b0, 3, 1'b0);
        run_op(8'hAC, 1'b0, 0, 1'b1);
        run_op(8'hBC, 1'b0, 4, 1'b0);
        run_op(8'h9D, 1'b1, 0, 1'b0);
        run_op(8'h00, 1'b0, 0, 1'b0);
        // constrained random
        for (int n = 0; n < 60; n++) begin
            logic [7:0] opc;
            case ($urandom % 4)
                0: opc = 8'h9C;
                1: opc = 8'hAC;
                2: opc = 8'hBC;
                default: opc = 8'($urandom);
            endcase
            run_op(opc, 1'($urandom), int'($urandom % 5), 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule